// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block is a single-cycle signed multiply-accumulate datapath. Two 16-bit two's complement operands are captured into their own holding registers from two independent input buses, each with its own load strobe. A 3-bit operation code from an external sequencer selects what happens at the next clock edge:
- plain multiply, which replaces the accumulator with the product
- multiply and add the product to the accumulator
- multiply and subtract the product from the accumulator
- saturate the accumulator
- hold

A separate clear input zeroes the accumulator and takes priority over any operation code.

The product is the exact 32-bit signed result. It is formed by a radix-4 Booth multiplier with fully sign-extended partial products and a carry-lookahead final adder. The accumulator is 40 bits wide: 32 product bits plus 8 guard bits. The low 32 bits of the accumulator drive the result bus. An overflow flag reports when the guard bits are not a plain sign extension of bit 31. A saturate operation clamps such a value to the nearest 32-bit extreme.

Top module: `mac_unit`

## Requirements
- R1: While rst_ni is low, and after it is released before any operation, result_o is 0 and overflow_o is 0; both operand registers read as 0, so a multiply issued then yields 0.
- R2: An operand register captures its bus only on a clock edge where its load strobe is high; otherwise it holds its value.
- R3: Op code 3'd1 (multiply) sets the accumulator to the sign-extended 32-bit signed product of the two operand registers, including -32768 x -32768 = 0x4000_0000.
- R4: Op code 3'd2 adds the sign-extended product to the 40-bit accumulator.
- R5: Op code 3'd3 subtracts the sign-extended product from the 40-bit accumulator.
- R6: An operation uses the operand register values held before the edge on which it is issued, so an operand loaded in the same cycle is first used by the next operation.
- R7: After op code 3'd1, 3'd2 or 3'd3, overflow_o is 1 exactly when accumulator bits 39..31 are not all equal. The flag holds its value on a hold code. It returns to 0 on clear or saturate.
- R8: Op code 3'd4 (saturate) works as follows when bits 39..31 are not all equal. A non-negative accumulator (bit 39 = 0) becomes 0x7FFF_FFFF on result_o. A negative one becomes 0x8000_0000 on result_o. Otherwise the accumulator is unchanged.
- R9: clr_i high sets the accumulator and overflow_o to 0 at the next edge, whatever op_i holds.
- R10: Op codes 3'd0, 3'd5, 3'd6 and 3'd7 leave the accumulator and overflow_o unchanged.
- R11: result_o shows accumulator bits 31..0 and changes on the clock edge that ends the cycle in which the operation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_bus_i | input | 16 | Operand A input bus |
| a_load_i | input | 1 | Capture a_bus_i into operand register A |
| b_bus_i | input | 16 | Operand B input bus |
| b_load_i | input | 1 | Capture b_bus_i into operand register B |
| op_i | input | 3 | Operation code |
| clr_i | input | 1 | Clear accumulator and flag (highest priority) |
| result_o | output | 32 | Accumulator bits 31..0 |
| overflow_o | output | 1 | Guard bits are not a sign extension of bit 31 |

## Verification
Two pairs of functions can fall in the same cycle. The first is clear together with an accumulate code. The bench raises clr_i while op_i asks for multiply-add on non-zero operands, at a moment when the overflow flag is already set. It judges the result by seeing zero and a low flag one edge later. The second is an operand load together with an operation. The bench loads new values in the same cycle as a multiply. It expects the product of the old operands first, then the product of the new ones on the following multiply.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OPND_W  = 16;
  localparam int unsigned PROD_W  = 2 * OPND_W;
  localparam int unsigned GUARD_W = 8;
  localparam int unsigned ACC_W   = PROD_W + GUARD_W;
  localparam int unsigned OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_MUL = 3'd1,
    OP_MAC = 3'd2,
    OP_MSB = 3'd3,
    OP_SAT = 3'd4
  } mac_op_e;

  typedef struct packed {
    logic ld;
    logic add;
    logic sub;
    logic sat;
  } acc_ctl_t;
endpackage

// File: rtl/mac_cla.sv
// Carry-lookahead adder, 4-bit groups, group carries chained.
module mac_cla #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned NG = W / 4;

  logic [NG:0] gc;
  assign gc[0] = ci_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [3:0] p, k, c;
    logic       grp_g, grp_p;
    assign p = a_i[4*g +: 4] ^ b_i[4*g +: 4];
    assign k = a_i[4*g +: 4] & b_i[4*g +: 4];
    assign c[0] = gc[g];
    assign c[1] = k[0] | (p[0] & gc[g]);
    assign c[2] = k[1] | (p[1] & k[0]) | (p[1] & p[0] & gc[g]);
    assign c[3] = k[2] | (p[2] & k[1]) | (p[2] & p[1] & k[0])
                | (p[2] & p[1] & p[0] & gc[g]);
    assign grp_g = k[3] | (p[3] & k[2]) | (p[3] & p[2] & k[1])
                 | (p[3] & p[2] & p[1] & k[0]);
    assign grp_p = &p;
    assign gc[g+1] = grp_g | (grp_p & gc[g]);
    assign s_o[4*g +: 4] = p ^ c;
  end
endmodule

// File: rtl/mac_booth_mul.sv
// Radix-4 Booth multiplier, full-width sign-extended partial products.
module mac_booth_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned NPP = W / 2;
  localparam int unsigned PW  = 2 * W;

  logic [PW-1:0] ax;
  logic [PW-1:0] pp [NPP];
  logic [PW-1:0] psum;

  assign ax = {{W{a_i[W-1]}}, a_i};

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic [2:0]    trip;
    logic [PW-1:0] mult;
    if (i == 0) begin : g_lo
      assign trip = {b_i[1], b_i[0], 1'b0};
    end else begin : g_hi
      assign trip = b_i[2*i+1 : 2*i-1];
    end
    always_comb begin
      unique case (trip)
        3'b001, 3'b010: mult = ax;
        3'b011:         mult = ax << 1;
        3'b100:         mult = -(ax << 1);
        3'b101, 3'b110: mult = -ax;
        default:        mult = '0;
      endcase
    end
    assign pp[i] = mult << (2 * i);
  end

  always_comb begin
    psum = '0;
    for (int k = 0; k < NPP - 1; k++) psum = psum + pp[k];
  end

  mac_cla #(.W(PW)) u_final (
    .a_i (psum),
    .b_i (pp[NPP-1]),
    .ci_i(1'b0),
    .s_o (p_o)
  );
endmodule

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output acc_ctl_t        ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_MUL:  ctl_o.ld  = 1'b1;
      OP_MAC:  ctl_o.add = 1'b1;
      OP_MSB:  ctl_o.sub = 1'b1;
      OP_SAT:  ctl_o.sat = 1'b1;
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int unsigned PW = PROD_W,
  parameter int unsigned AW = ACC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  acc_ctl_t      ctl_i,
  input  logic [PW-1:0] prod_i,
  output logic [AW-1:0] acc_o,
  output logic          ovf_o
);
  localparam int unsigned GW = AW - PW;
  localparam logic [AW-1:0] SAT_POS = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_NEG = {{(GW+1){1'b1}}, {(PW-1){1'b0}}};

  logic [AW-1:0] acc_q, acc_d, pe, addend, sum;
  logic          ovf_q, ovf_d;

  function automatic logic guard_bad(input logic [AW-1:0] v);
    return !((&v[AW-1:PW-1]) || !(|v[AW-1:PW-1]));
  endfunction

  assign pe     = {{GW{prod_i[PW-1]}}, prod_i};
  assign addend = ctl_i.sub ? ~pe : pe;

  mac_cla #(.W(AW)) u_add (
    .a_i (acc_q),
    .b_i (addend),
    .ci_i(ctl_i.sub),
    .s_o (sum)
  );

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (clr_i) begin
      acc_d = '0;
      ovf_d = 1'b0;
    end else if (ctl_i.ld) begin
      acc_d = pe;
      ovf_d = guard_bad(pe);
    end else if (ctl_i.add || ctl_i.sub) begin
      acc_d = sum;
      ovf_d = guard_bad(sum);
    end else if (ctl_i.sat) begin
      if (guard_bad(acc_q)) acc_d = acc_q[AW-1] ? SAT_NEG : SAT_POS;
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPND_W-1:0] a_bus_i,
  input  logic              a_load_i,
  input  logic [OPND_W-1:0] b_bus_i,
  input  logic              b_load_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              clr_i,
  output logic [PROD_W-1:0] result_o,
  output logic              overflow_o
);
  logic [OPND_W-1:0] opa_q, opb_q;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q;
  acc_ctl_t          ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (a_load_i) opa_q <= a_bus_i;
      if (b_load_i) opb_q <= b_bus_i;
    end
  end

  mac_decode u_dec (
    .op_i (op_i),
    .ctl_o(ctl)
  );

  mac_booth_mul #(.W(OPND_W)) u_mul (
    .a_i(opa_q),
    .b_i(opb_q),
    .p_o(prod)
  );

  mac_acc #(.PW(PROD_W), .AW(ACC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .ctl_i (ctl),
    .prod_i(prod),
    .acc_o (acc_q),
    .ovf_o (overflow_o)
  );

  assign result_o = acc_q[PROD_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
  import mac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_load_i,
  input logic              b_load_i,
  input logic [OP_W-1:0]   op_i,
  input logic              clr_i,
  input logic [PROD_W-1:0] result_o,
  input logic              overflow_o,
  input logic [OPND_W-1:0] opa_q,
  input logic [OPND_W-1:0] opb_q,
  input logic [ACC_W-1:0]  acc_q
);
  logic signed [PROD_W-1:0] ref_p;
  logic                     arith, is_nop, guard_ok;

  assign ref_p    = $signed(opa_q) * $signed(opb_q);
  assign arith    = (op_i == OP_MUL) || (op_i == OP_MAC) || (op_i == OP_MSB);
  assign is_nop   = (op_i == 3'd0) || (op_i > 3'd4);
  assign guard_ok = (&acc_q[ACC_W-1:PROD_W-1]) || !(|acc_q[ACC_W-1:PROD_W-1]);

  AST_OPA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_load_i |=> $stable(opa_q)); // R2
  AST_OPB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_load_i |=> $stable(opb_q)); // R2
  AST_MUL_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && op_i == OP_MUL) |=> result_o == $past(ref_p)); // R3
  AST_OVF_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && arith) |=> overflow_o == !guard_ok); // R7
  AST_SAT_FIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && op_i == OP_SAT) |=> guard_ok && !overflow_o); // R8
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0) && !overflow_o); // R9
  AST_NOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && is_nop) |=> $stable(acc_q) && $stable(overflow_o)); // R10
endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_load_i  (a_load_i),
  .b_load_i  (b_load_i),
  .op_i      (op_i),
  .clr_i     (clr_i),
  .result_o  (result_o),
  .overflow_o(overflow_o),
  .opa_q     (opa_q),
  .opb_q     (opb_q),
  .acc_q     (acc_q)
);

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_bus_i = '0, b_bus_i = '0;
  logic        a_load_i = 1'b0, b_load_i = 1'b0, clr_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] result_o;
  logic        overflow_o;

  int n_chk = 0, n_fail = 0;

  logic signed [15:0] m_a = '0, m_b = '0;
  logic signed [39:0] m_acc = '0;
  logic               m_ovf = 1'b0;

  mac_unit u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  function automatic logic bad(input logic [39:0] v);
    return !((&v[39:31]) || !(|v[39:31]));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " result"}, result_o, m_acc[31:0]);
    chk({tag, " overflow"}, {31'd0, overflow_o}, {31'd0, m_ovf});
  endtask

  // Drive one cycle after a falling edge; update the model once the rising edge is past.
  task automatic step(input logic [15:0] a, input logic la, input logic [15:0] b,
                      input logic lb, input logic [2:0] op, input logic clr);
    logic signed [31:0] p;
    logic signed [39:0] pe;
    @(negedge clk_i);
    a_bus_i = a; a_load_i = la; b_bus_i = b; b_load_i = lb; op_i = op; clr_i = clr;
    @(posedge clk_i);
    #1;
    p  = m_a * m_b;
    pe = p;
    if (clr) begin
      m_acc = '0; m_ovf = 1'b0;
    end else begin
      case (op)
        3'd1: begin m_acc = pe; m_ovf = bad(m_acc); end
        3'd2: begin m_acc = m_acc + pe; m_ovf = bad(m_acc); end
        3'd3: begin m_acc = m_acc - pe; m_ovf = bad(m_acc); end
        3'd4: begin
          if (bad(m_acc)) m_acc = m_acc[39] ? -40'sh80000000 : 40'sh7FFFFFFF;
          m_ovf = 1'b0;
        end
        default: ;
      endcase
    end
    if (la) m_a = a;
    if (lb) m_b = b;
  endtask

  task automatic idle();
    step('0, 1'b0, '0, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    step(a, 1'b1, b, 1'b1, 3'd0, 1'b0);
  endtask

  task automatic t_reset();
    #3;
    chk("R1 reset result", result_o, 32'h0);
    chk("R1 reset overflow", {31'd0, overflow_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
    chk("R1 mul after reset", result_o, 32'h0);
  endtask

  task automatic t_load_hold();
    load(16'd7, 16'd9);
    step(16'd1000, 1'b0, 16'd1000, 1'b0, 3'd1, 1'b0);
    chk("R2 no-load hold", result_o, 32'd63);
    step(16'd5, 1'b1, 16'd0, 1'b0, 3'd0, 1'b0);
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
    chk("R2 load A only", result_o, 32'd45);
  endtask

  task automatic t_mul();
    logic [15:0] av [5] = '{16'h8000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [15:0] bv [5] = '{16'h8000, 16'h7FFF, 16'h7FFF, 16'h0003, 16'hEDCC};
    for (int i = 0; i < 5; i++) begin
      load(av[i], bv[i]);
      step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
      chk_model("R3 multiply");
    end
    load(16'h8000, 16'h8000);
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
    chk("R3 min*min", result_o, 32'h4000_0000);
  endtask

  task automatic t_accum();
    step('0, 1'b0, '0, 1'b0, 3'd0, 1'b1);
    load(16'd300, 16'hFFF6);           // 300 * -10
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    chk("R4 mac from zero", result_o, -32'sd3000);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    chk("R4 mac twice", result_o, -32'sd6000);
    load(16'd50, 16'd40);
    step('0, 1'b0, '0, 1'b0, 3'd3, 1'b0);
    chk("R5 msb", result_o, -32'sd8000);
    load(16'hFFFF, 16'd8000);          // -8000
    step('0, 1'b0, '0, 1'b0, 3'd3, 1'b0);
    chk("R5 msb of negative", result_o, 32'd0);
    chk_model("R5 model");
  endtask

  task automatic t_same_cycle_load();
    load(16'd3, 16'd4);
    step(16'd100, 1'b1, 16'd100, 1'b1, 3'd1, 1'b0);
    chk("R6 old operands used", result_o, 32'd12);
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
    chk("R6 new operands next", result_o, 32'd10000);
  endtask

  task automatic t_latency();
    load(16'd11, 16'd13);
    @(negedge clk_i);
    op_i = 3'd1; a_load_i = 1'b0; b_load_i = 1'b0; clr_i = 1'b0;
    #1;
    chk("R11 before edge", result_o, 32'd10000);
    @(posedge clk_i); #1;
    m_acc = 40'sd143; m_ovf = 1'b0;
    chk("R11 after edge", result_o, 32'd143);
    idle();
  endtask

  task automatic t_sat_pos();
    step('0, 1'b0, '0, 1'b0, 3'd0, 1'b1);
    load(16'h8000, 16'h8000);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    chk("R7 in range no ovf", {31'd0, overflow_o}, 32'd0);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    chk("R7 ovf set", {31'd0, overflow_o}, 32'd1);
    chk("R7 low bits", result_o, 32'h8000_0000);
    for (int c = 0; c < 8; c++) begin
      step('0, 1'b0, '0, 1'b0, (c[0] ? 3'd5 : 3'd0), 1'b0);
    end
    chk("R7 ovf held on hold codes", {31'd0, overflow_o}, 32'd1);
    step('0, 1'b0, '0, 1'b0, 3'd4, 1'b0);
    chk("R8 sat positive", result_o, 32'h7FFF_FFFF);
    chk("R7 sat clears ovf", {31'd0, overflow_o}, 32'd0);
  endtask

  task automatic t_sat_neg();
    step('0, 1'b0, '0, 1'b0, 3'd0, 1'b1);
    load(16'h8000, 16'h8000);
    for (int c = 0; c < 3; c++) step('0, 1'b0, '0, 1'b0, 3'd3, 1'b0);
    chk("R7 neg ovf", {31'd0, overflow_o}, 32'd1);
    chk("R5 neg low bits", result_o, 32'h4000_0000);
    step('0, 1'b0, '0, 1'b0, 3'd4, 1'b0);
    chk("R8 sat negative", result_o, 32'h8000_0000);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    chk("R8 sat value is -2^31", result_o, 32'hC000_0000);
    chk_model("R8 model after sat");
  endtask

  task automatic t_sat_in_range();
    load(16'hFFFF, 16'd1234);
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
    step('0, 1'b0, '0, 1'b0, 3'd4, 1'b0);
    chk("R8 sat in range unchanged", result_o, -32'sd1234);
  endtask

  task automatic t_clr_priority();
    step('0, 1'b0, '0, 1'b0, 3'd0, 1'b1);
    load(16'h8000, 16'h8000);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b0);
    chk("R9 ovf before clear", {31'd0, overflow_o}, 32'd1);
    step('0, 1'b0, '0, 1'b0, 3'd2, 1'b1);
    chk("R9 clear beats mac", result_o, 32'd0);
    chk("R9 clear drops ovf", {31'd0, overflow_o}, 32'd0);
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b1);
    chk("R9 clear beats mul", result_o, 32'd0);
  endtask

  task automatic t_nop_codes();
    logic [2:0] codes [4] = '{3'd0, 3'd5, 3'd6, 3'd7};
    load(16'd321, 16'd3);
    step('0, 1'b0, '0, 1'b0, 3'd1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step('0, 1'b0, '0, 1'b0, codes[i], 1'b0);
      chk("R10 hold code", result_o, 32'd963);
    end
  endtask

  initial begin
    t_reset();
    t_load_hold();
    t_mul();
    t_accum();
    t_same_cycle_load();
    t_latency();
    t_sat_pos();
    t_sat_neg();
    t_sat_in_range();
    t_clr_priority();
    t_nop_codes();
    idle();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule